// File: doc/BRIEF.md
# Floating-Point Compare and Status Unit

This unit compares two IEEE-754 double-precision operands and turns the outcome into a 4-bit condition code. The code is written in two places. One is a condition-register field chosen by a 3-bit index. The other is a 4-bit result field that is spliced into the floating-point status word presented on `status_i`. When either operand is a NaN, the unit raises invalid-operation flags. A mode input chooses between a quiet compare and an ordered compare.

A compare is launched by a one-cycle `start_i` strobe. All outcomes appear together, registered, one cycle later, marked by a single-cycle `done_o` pulse. The unordered code is always written, even when the same compare also reports an invalid-operation exception. If the floating-point unit is disabled, the compare writes nothing. It reports an unavailable exception instead.

The exception flags are pulses valid only in the done cycle. They therefore start clear for every compare. Arithmetic, rounding, trap delivery and instruction decode are handled elsewhere.

Top module: `fpcmp_unit`

## Requirements
- R1: The condition code is 4'b1000 for A<B, 4'b0100 for A>B, 4'b0010 for A==B and 4'b0001 (unordered) when either operand is a NaN. The NaN test has priority, then less-than, then greater-than, and equal is the remaining case.
- R2: A NaN has exponent bits [62:52] all ones and a non-zero fraction [51:0]. It is signalling when bit 51 is 0 and quiet when bit 51 is 1. Infinities are not NaNs.
- R3: +0 and -0 compare equal. Other values order by sign and then magnitude, with the magnitude order reversed when both operands are negative. Infinities are the extreme values.
- R4: On an enabled compare, `status_o` equals `status_i` with bits [15:12] replaced by the code. All other bits are kept, and `status_we_o` is high.
- R5: On an enabled compare, `crf_we_o` is high, `crf_idx_o` equals the `crf_idx_i` of the start cycle, and `crf_val_o` carries the code.
- R6: An unordered result still writes both the condition field and the status field with 4'b0001, in the same cycle as any invalid-operation flag.
- R7: In quiet mode (`ordered_i`=0), an unordered result with a signalling-NaN operand raises `exc_snan_o`. Quiet NaNs alone raise no flag.
- R8: In ordered mode (`ordered_i`=1), an unordered result raises `exc_snan_o` if either operand is a signalling NaN. Otherwise it raises `exc_cmp_o`. The two flags are never high together.
- R9: With `fpu_en_i` low, a compare raises `exc_fpu_o`. It leaves `crf_we_o` and `status_we_o` low, and it leaves `status_o` and `crf_val_o` unchanged.
- R10: Every output of a compare appears one cycle after the start strobe, with `done_o` high for that one cycle. In cycles without `done_o`, all write enables and exception flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch a compare this cycle |
| ordered_i | input | 1 | 1 = ordered compare, 0 = quiet compare |
| fpu_en_i | input | 1 | Floating-point unit enabled |
| op_a_i | input | 64 | Operand A, double precision |
| op_b_i | input | 64 | Operand B, double precision |
| crf_idx_i | input | 3 | Destination condition field index |
| status_i | input | 32 | Current floating-point status word |
| done_o | output | 1 | Compare finished (one-cycle pulse) |
| crf_we_o | output | 1 | Condition field write enable |
| crf_idx_o | output | 3 | Condition field index to write |
| crf_val_o | output | 4 | Condition code to write |
| status_we_o | output | 1 | Status word write enable |
| status_o | output | 32 | Updated status word |
| exc_snan_o | output | 1 | Invalid operation: signalling NaN |
| exc_cmp_o | output | 1 | Invalid operation: ordered compare of quiet NaN |
| exc_fpu_o | output | 1 | Floating-point unit unavailable |

## Verification
The assertions check the following on every cycle:
- a written code is always one-hot and matches the status field;
- bits outside the status field follow the prior `status_i`;
- an invalid flag only accompanies an unordered write;
- the compare flag never appears in quiet mode;
- a disabled compare never writes;
- done follows start by exactly one cycle.

Only the directed scenarios can show that the code is correct for each operand class. That covers signed zeros, negative pairs, infinities, and signalling versus quiet NaNs in either slot. The scenarios also show that a disabled compare leaves the previously written status and code in place.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;
  localparam int unsigned CC_W = 4;

  typedef enum logic [CC_W-1:0] {
    CC_LT = 4'b1000,
    CC_GT = 4'b0100,
    CC_EQ = 4'b0010,
    CC_UN = 4'b0001
  } cc_e;

  typedef struct packed {
    logic is_nan;
    logic is_snan;
  } opclass_t;
endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify #(
  parameter int unsigned EXP_W  = 11,
  parameter int unsigned FRAC_W = 52,
  localparam int unsigned DATA_W = 1 + EXP_W + FRAC_W
) (
  input  logic [DATA_W-1:0]    op_i,
  output fpcmp_pkg::opclass_t  cls_o
);
  logic [EXP_W-1:0]  exp_w;
  logic [FRAC_W-1:0] frac_w;
  logic              sign_w;

  assign {sign_w, exp_w, frac_w} = op_i;

  always_comb begin
    cls_o.is_nan  = (&exp_w) && (|frac_w);
    // top fraction bit clear marks the signalling flavour
    cls_o.is_snan = cls_o.is_nan && !frac_w[FRAC_W-1];
  end

  logic unused_sign;
  assign unused_sign = sign_w;
endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order #(
  parameter int unsigned DATA_W = 64,
  localparam int unsigned MAG_W = DATA_W - 1
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              lt_o,
  output logic              le_o
);
  logic             sa, sb;
  logic [MAG_W-1:0] ma, mb;
  logic             both_zero, same_bits;

  assign {sa, ma} = a_i;
  assign {sb, mb} = b_i;
  assign both_zero = (ma == '0) && (mb == '0);
  assign same_bits = (a_i == b_i);

  always_comb begin
    if (both_zero)     lt_o = 1'b0;
    else if (sa != sb) lt_o = sa;
    else if (!sa)      lt_o = ma < mb;
    else               lt_o = ma > mb;
    le_o = lt_o || both_zero || same_bits;
  end
endmodule

// File: rtl/fpcmp_result.sv
module fpcmp_result
  import fpcmp_pkg::*;
(
  input  opclass_t        cls_a_i,
  input  opclass_t        cls_b_i,
  input  logic            lt_i,
  input  logic            le_i,
  input  logic            ordered_i,
  output logic [CC_W-1:0] code_o,
  output logic            snan_o,
  output logic            vc_o
);
  logic any_nan, any_snan;

  assign any_nan  = cls_a_i.is_nan  || cls_b_i.is_nan;
  assign any_snan = cls_a_i.is_snan || cls_b_i.is_snan;

  always_comb begin
    if (any_nan)    code_o = CC_UN;
    else if (lt_i)  code_o = CC_LT;
    else if (!le_i) code_o = CC_GT;
    else            code_o = CC_EQ;
  end

  // flags derive only from the unordered outcome, after the code is fixed
  always_comb begin
    snan_o = 1'b0;
    vc_o   = 1'b0;
    if (code_o == CC_UN) begin
      if (any_snan)       snan_o = 1'b1;
      else if (ordered_i) vc_o   = 1'b1;
    end
  end
endmodule

// File: rtl/fpcmp_unit.sv
module fpcmp_unit
  import fpcmp_pkg::*;
#(
  parameter int unsigned EXP_W    = 11,
  parameter int unsigned FRAC_W   = 52,
  parameter int unsigned IDX_W    = 3,
  parameter int unsigned STAT_W   = 32,
  parameter int unsigned FLAG_LSB = 12,
  localparam int unsigned DATA_W  = 1 + EXP_W + FRAC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              ordered_i,
  input  logic              fpu_en_i,
  input  logic [DATA_W-1:0] op_a_i,
  input  logic [DATA_W-1:0] op_b_i,
  input  logic [IDX_W-1:0]  crf_idx_i,
  input  logic [STAT_W-1:0] status_i,
  output logic              done_o,
  output logic              crf_we_o,
  output logic [IDX_W-1:0]  crf_idx_o,
  output logic [CC_W-1:0]   crf_val_o,
  output logic              status_we_o,
  output logic [STAT_W-1:0] status_o,
  output logic              exc_snan_o,
  output logic              exc_cmp_o,
  output logic              exc_fpu_o
);
  localparam logic [STAT_W-1:0] FLD_MASK =
    {{(STAT_W-CC_W){1'b0}}, {CC_W{1'b1}}} << FLAG_LSB;

  logic [DATA_W-1:0] ops [2];
  opclass_t          cls [2];
  logic              lt_w, le_w, snan_w, vc_w;
  logic [CC_W-1:0]   code_w;
  logic [STAT_W-1:0] stat_next;

  assign ops[0] = op_a_i;
  assign ops[1] = op_b_i;

  for (genvar g = 0; g < 2; g++) begin : g_cls
    fpcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .op_i  (ops[g]),
      .cls_o (cls[g])
    );
  end

  fpcmp_order #(.DATA_W(DATA_W)) u_order (
    .a_i  (op_a_i),
    .b_i  (op_b_i),
    .lt_o (lt_w),
    .le_o (le_w)
  );

  fpcmp_result u_result (
    .cls_a_i   (cls[0]),
    .cls_b_i   (cls[1]),
    .lt_i      (lt_w),
    .le_i      (le_w),
    .ordered_i (ordered_i),
    .code_o    (code_w),
    .snan_o    (snan_w),
    .vc_o      (vc_w)
  );

  always_comb begin
    stat_next = status_i;
    stat_next[FLAG_LSB +: CC_W] = code_w;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o      <= 1'b0;
      crf_we_o    <= 1'b0;
      crf_idx_o   <= '0;
      crf_val_o   <= '0;
      status_we_o <= 1'b0;
      status_o    <= '0;
      exc_snan_o  <= 1'b0;
      exc_cmp_o   <= 1'b0;
      exc_fpu_o   <= 1'b0;
    end else begin
      done_o      <= start_i;
      crf_we_o    <= start_i && fpu_en_i;
      status_we_o <= start_i && fpu_en_i;
      exc_snan_o  <= start_i && fpu_en_i && snan_w;
      exc_cmp_o   <= start_i && fpu_en_i && vc_w;
      exc_fpu_o   <= start_i && !fpu_en_i;
      if (start_i && fpu_en_i) begin
        crf_idx_o <= crf_idx_i;
        crf_val_o <= code_w;
        status_o  <= stat_next;
      end
    end
  end

  AST_CODE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crf_we_o |-> $countones(crf_val_o) == 1) else $error("code not one-hot"); // R1
  AST_STATUS_FIELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_we_o |-> status_o[FLAG_LSB +: CC_W] == crf_val_o) else $error("field mismatch"); // R4
  AST_KEEP_OTHER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && fpu_en_i |=> (status_o & ~FLD_MASK) == ($past(status_i) & ~FLD_MASK))
    else $error("status bits disturbed"); // R4
  AST_IDX_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && fpu_en_i |=> crf_idx_o == $past(crf_idx_i)) else $error("index"); // R5
  AST_EXC_WRITES_UN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_snan_o || exc_cmp_o) |-> crf_we_o && status_we_o && crf_val_o == CC_UN)
    else $error("exception without unordered write"); // R6
  AST_QUIET_NO_VC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !ordered_i |=> !exc_cmp_o) else $error("quiet raised compare flag"); // R7
  AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(exc_snan_o && exc_cmp_o)) else $error("both invalid flags"); // R8
  AST_DISABLED_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_fpu_o |-> !crf_we_o && !status_we_o && !exc_snan_o && !exc_cmp_o)
    else $error("write while disabled"); // R9
  AST_DONE_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> done_o) else $error("done missing"); // R10
  AST_QUIET_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> !crf_we_o && !status_we_o && !exc_snan_o && !exc_cmp_o && !exc_fpu_o)
    else $error("activity without done"); // R10
endmodule

// File: tb/fpcmp_unit_bench.sv
module fpcmp_unit_bench;
  localparam logic [63:0] P_ONE  = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] P_TWO  = 64'h4000_0000_0000_0000;
  localparam logic [63:0] N_ONE  = 64'hBFF0_0000_0000_0000;
  localparam logic [63:0] N_TWO  = 64'hC000_0000_0000_0000;
  localparam logic [63:0] P_ZERO = 64'h0000_0000_0000_0000;
  localparam logic [63:0] N_ZERO = 64'h8000_0000_0000_0000;
  localparam logic [63:0] P_INF  = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] N_INF  = 64'hFFF0_0000_0000_0000;
  localparam logic [63:0] QNAN   = 64'h7FF8_0000_0000_0000;
  localparam logic [63:0] NQNAN  = 64'hFFF8_0000_0000_0001;
  localparam logic [63:0] SNAN   = 64'h7FF0_0000_0000_0001;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0, ordered_i = 1'b0, fpu_en_i = 1'b1;
  logic [63:0] op_a_i = '0, op_b_i = '0;
  logic [2:0]  crf_idx_i = '0;
  logic [31:0] status_i = '0;
  logic done_o, crf_we_o, status_we_o, exc_snan_o, exc_cmp_o, exc_fpu_o;
  logic [2:0]  crf_idx_o;
  logic [3:0]  crf_val_o;
  logic [31:0] status_o;

  int n_chk = 0, n_fail = 0, cycles = 0;
  bit finished = 0;

  always #4 clk_i = ~clk_i;

  fpcmp_unit u_fpcmp_unit (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_cmp(string req, logic [63:0] a, logic [63:0] b, logic ord,
                         logic [2:0] idx, logic [31:0] st, logic [3:0] code,
                         logic e_snan, logic e_cmp);
    @(negedge clk_i);
    op_a_i = a; op_b_i = b; ordered_i = ord; fpu_en_i = 1'b1;
    crf_idx_i = idx; status_i = st; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk({req, " code"}, crf_val_o, code);
    chk("R10 done", done_o, 1'b1);
    chk("R5 crf_we", crf_we_o, 1'b1);
    chk("R5 crf_idx", crf_idx_o, idx);
    chk("R4 status_we", status_we_o, 1'b1);
    chk("R4 status", status_o, (st & ~32'h0000_F000) | ({28'd0, code} << 12));
    chk({req, " snan flag"}, exc_snan_o, e_snan);
    chk({req, " cmp flag"}, exc_cmp_o, e_cmp);
    chk("R9 fpu flag", exc_fpu_o, 1'b0);
    @(negedge clk_i);
    chk("R10 done pulse", done_o, 1'b0);
    chk("R10 flags clear", {crf_we_o, status_we_o, exc_snan_o, exc_cmp_o}, 4'b0);
  endtask

  task automatic run_disabled();
    logic [31:0] st_prev;
    logic [3:0]  cv_prev;
    st_prev = status_o;
    cv_prev = crf_val_o;
    @(negedge clk_i);
    op_a_i = SNAN; op_b_i = P_ONE; ordered_i = 1'b1; fpu_en_i = 1'b0;
    status_i = 32'h1234_5678; crf_idx_i = 3'd6; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0; fpu_en_i = 1'b1;
    chk("R9 fpu exc", exc_fpu_o, 1'b1);
    chk("R9 done", done_o, 1'b1);
    chk("R9 no writes", {crf_we_o, status_we_o, exc_snan_o, exc_cmp_o}, 4'b0);
    chk("R9 status held", status_o, st_prev);
    chk("R9 code held", crf_val_o, cv_prev);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R10 reset done", done_o, 1'b0);
    chk("R10 reset enables", {crf_we_o, status_we_o, exc_fpu_o}, 3'b0);
    rst_ni = 1'b1;
    run_cmp("R1 lt", P_ONE, P_TWO, 1'b0, 3'd0, 32'hA5A5_F0F0, 4'b1000, 0, 0);
    run_cmp("R1 gt", P_TWO, P_ONE, 1'b0, 3'd1, 32'h0000_0000, 4'b0100, 0, 0);
    run_cmp("R1 eq", P_TWO, P_TWO, 1'b1, 3'd7, 32'hFFFF_FFFF, 4'b0010, 0, 0);
    run_cmp("R3 zeros", P_ZERO, N_ZERO, 1'b0, 3'd2, 32'h0F0F_0F0F, 4'b0010, 0, 0);
    run_cmp("R3 neg pair", N_TWO, N_ONE, 1'b0, 3'd3, 32'h0, 4'b1000, 0, 0);
    run_cmp("R3 neg pair gt", N_ONE, N_TWO, 1'b0, 3'd3, 32'h0, 4'b0100, 0, 0);
    run_cmp("R3 sign", N_ONE, P_ZERO, 1'b0, 3'd4, 32'h0, 4'b1000, 0, 0);
    run_cmp("R3 inf", P_INF, P_TWO, 1'b0, 3'd5, 32'h0, 4'b0100, 0, 0);
    run_cmp("R3 ninf", N_INF, N_TWO, 1'b0, 3'd5, 32'h0, 4'b1000, 0, 0);
    run_cmp("R2 inf eq", P_INF, P_INF, 1'b1, 3'd1, 32'h0, 4'b0010, 0, 0);
    run_cmp("R7 quiet qnan", QNAN, P_ONE, 1'b0, 3'd6, 32'h8000_0001, 4'b0001, 0, 0);
    run_cmp("R7 quiet snan", P_ONE, SNAN, 1'b0, 3'd6, 32'h0, 4'b0001, 1, 0);
    run_cmp("R8 ordered qnan", P_ONE, NQNAN, 1'b1, 3'd2, 32'hDEAD_BEEF, 4'b0001, 0, 1);
    run_cmp("R8 ordered snan", SNAN, QNAN, 1'b1, 3'd0, 32'h0, 4'b0001, 1, 0);
    run_cmp("R6 nan vs inf", QNAN, P_INF, 1'b1, 3'd4, 32'h5555_5555, 4'b0001, 0, 1);
    run_disabled();
    finish_run();
  end

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected <= 20000 cycles", cycles);
      finish_run();
    end
  end
endmodule